// File: doc/BRIEF.md
# Idle-Suppressing Byte Packer

This block follows the 8b/10b decoder in a serial sensor readout path. Each cycle it may take one decoded byte, together with a flag that marks the byte as a control (k) character and a flag that marks a decode error. Idle characters are removed from the stream. Every other byte is collected into a group of up to three payload bytes. A group leaves as one 32-bit word whose top byte is a status byte.

A group closes in one of three ways: its third byte arrives, a non-idle control character arrives, or the flush input is raised. A word that holds fewer than three payload bytes still leaves, and its status byte gives the number of valid lanes. Words go to a downstream buffer FIFO through a valid/ready pair. The block has no input buffering. A byte that arrives while the FIFO is not ready is lost, and the next word records that loss in a sticky overflow bit.

The idle code is a parameter whose default is the decoded value of the K28.5 comma, 0xBC. A byte with the value 0xBC is treated as idle only when its k flag is set.

Top module: `idle_byte_packer`

## Requirements
- R1: A byte presented with in_valid=1, in_is_k=1 and in_byte equal to IDLE_CODE (default 0xBC) is discarded. It does not occupy a lane, and its in_err flag is ignored. The same value with in_is_k=0 is ordinary data.
- R2: Accepted bytes fill lanes in arrival order. The first byte goes to bits 7:0, the second to bits 15:8 and the third to bits 23:16. The cycle after the edge at which the third byte is accepted, out_valid is high and out_word holds the group.
- R3: The status byte, out_word[31:24], is laid out as follows: bits 1:0 hold the count of valid payload bytes (1 to 3), bit 2 is the error flag, bit 3 is the control flag, bit 4 is the overflow flag, and bits 7:5 are zero.
- R4: A non-idle control character is stored as the next payload byte. It closes the group at once, and the word leaves with the control flag set.
- R5: A flush accepted while out_ready=1 closes a partially filled group. A byte accepted in the same cycle is included in that group. A flush while the group is empty produces no word.
- R6: Lanes above the valid count read as zero.
- R7: While out_valid=1 and out_ready=0, out_valid stays high and out_word stays unchanged.
- R8: A non-idle byte presented while out_ready=0 is dropped. The next word to leave has the overflow flag set, and the word after that has it clear again, unless a further byte is dropped in between.
- R9: The error flag of a word is set if any byte accepted into its group had in_err=1. The next group starts with the flag clear.
- R10: After reset, out_valid is low and the group is empty.
- R11: A cycle with in_valid=0 and flush=0 changes neither the group nor the output, apart from the normal drain of a word on out_ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A decoded byte is present this cycle |
| in_byte | input | 8 | Decoded byte |
| in_is_k | input | 1 | The byte is a control character |
| in_err | input | 1 | The decoder flagged this byte as an error |
| flush | input | 1 | Close the current partial group |
| out_ready | input | 1 | The downstream FIFO can take a word |
| out_valid | output | 1 | out_word holds a word |
| out_word | output | 32 | Status byte in bits 31:24, payload lanes 2..0 below it |

## Verification
The checker examines every cycle. It confirms that a stalled word holds steady, and that nothing new appears while the block is stalled with no word pending. It also checks that an idle byte or an empty input cycle never produces a word, and that each word has a legal count, zero reserved bits and zero unused lanes. The bench scenarios are needed to show the rest: the exact lane order, that every byte value passes through, the correct close on a control character or a flush, and the sticky behaviour of the error and overflow flags across group boundaries.

// File: rtl/ibp_pkg.sv
package ibp_pkg;
   localparam int unsigned STATUS_W = 8;

   typedef struct packed {
      logic [2:0] rsvd;
      logic       ovf;
      logic       ctrl;
      logic       err;
      logic [1:0] cnt;
   } ibp_status_t;
endpackage

// File: rtl/ibp_classify.sv
module ibp_classify #(
   parameter int unsigned         BYTE_W    = 8,
   parameter logic [BYTE_W-1:0]   IDLE_CODE = 8'hBC
) (
   input  logic              in_valid,
   input  logic [BYTE_W-1:0] in_byte,
   input  logic              in_is_k,
   input  logic              out_ready,
   output logic              take,
   output logic              drop,
   output logic              is_ctrl
);
   logic idle;
   logic live;

   assign idle    = in_is_k && (in_byte == IDLE_CODE);
   assign live    = in_valid && !idle;
   assign take    = live && out_ready;
   assign drop    = live && !out_ready;
   assign is_ctrl = take && in_is_k;
endmodule

// File: rtl/ibp_collect.sv
module ibp_collect
   import ibp_pkg::*;
#(
   parameter int unsigned BYTE_W    = 8,
   parameter int unsigned LANES     = 3,
   parameter bit          ZERO_FILL = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    take,
   input  logic                    drop,
   input  logic                    is_ctrl,
   input  logic                    byte_err,
   input  logic                    flush_en,
   input  logic [BYTE_W-1:0]       in_byte,
   output logic                    load,
   output logic [LANES*BYTE_W-1:0] lanes_flat,
   output ibp_status_t             status
);
   localparam int unsigned CNT_W = $clog2(LANES + 1);

   logic [CNT_W-1:0] cnt_q, cnt_n;
   logic             err_q, err_n;
   logic             ovf_q;

   assign cnt_n = cnt_q + CNT_W'(take);
   assign err_n = err_q | (take & byte_err);
   assign load  = (take && ((cnt_n == CNT_W'(LANES)) || is_ctrl))
                || (flush_en && (cnt_n != '0));

   always_comb begin
      status      = '0;
      status.cnt  = 2'(cnt_n);
      status.err  = err_n;
      status.ctrl = is_ctrl;
      status.ovf  = ovf_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         err_q <= 1'b0;
         ovf_q <= 1'b0;
      end else if (load) begin
         cnt_q <= '0;
         err_q <= 1'b0;
         ovf_q <= 1'b0;
      end else begin
         cnt_q <= cnt_n;
         err_q <= err_n;
         ovf_q <= ovf_q | drop;
      end
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic              hit;
      logic [BYTE_W-1:0] lane_q;

      assign hit = take && (cnt_q == CNT_W'(i));
      assign lanes_flat[i*BYTE_W +: BYTE_W] = hit ? in_byte : lane_q;

      if (ZERO_FILL) begin : g_clear
         always_ff @(posedge clk) begin
            if (!rst_n)      lane_q <= '0;
            else if (load)   lane_q <= '0;
            else if (hit)    lane_q <= in_byte;
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (!rst_n)      lane_q <= '0;
            else if (hit)    lane_q <= in_byte;
         end
      end
   end
endmodule

// File: rtl/ibp_out_reg.sv
module ibp_out_reg #(
   parameter int unsigned WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] word_in,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [WORD_W-1:0] out_word
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_word  <= '0;
      end else if (load) begin
         out_valid <= 1'b1;
         out_word  <= word_in;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/idle_byte_packer.sv
module idle_byte_packer
   import ibp_pkg::*;
#(
   parameter int unsigned       BYTE_W    = 8,
   parameter int unsigned       WORD_W    = 32,
   parameter logic [BYTE_W-1:0] IDLE_CODE = 8'hBC,
   parameter bit                ZERO_FILL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [BYTE_W-1:0] in_byte,
   input  logic              in_is_k,
   input  logic              in_err,
   input  logic              flush,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [WORD_W-1:0] out_word
);
   localparam int unsigned LANES = (WORD_W - STATUS_W) / BYTE_W;

   if (BYTE_W != STATUS_W) begin : g_bad_byte
      $error("byte width must equal status width");
   end
   if (WORD_W != STATUS_W + LANES * BYTE_W) begin : g_bad_word
      $error("word width must be status plus whole lanes");
   end
   if (LANES < 1 || LANES > 3) begin : g_bad_lanes
      $error("lane count must be 1 to 3");
   end

   logic                    take, drop, is_ctrl, load;
   logic [LANES*BYTE_W-1:0] lanes_flat;
   ibp_status_t             status;

   ibp_classify #(.BYTE_W(BYTE_W), .IDLE_CODE(IDLE_CODE)) u_cls (
      .in_valid (in_valid),
      .in_byte  (in_byte),
      .in_is_k  (in_is_k),
      .out_ready(out_ready),
      .take     (take),
      .drop     (drop),
      .is_ctrl  (is_ctrl)
   );

   ibp_collect #(.BYTE_W(BYTE_W), .LANES(LANES), .ZERO_FILL(ZERO_FILL)) u_col (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (take),
      .drop      (drop),
      .is_ctrl   (is_ctrl),
      .byte_err  (in_err),
      .flush_en  (flush && out_ready),
      .in_byte   (in_byte),
      .load      (load),
      .lanes_flat(lanes_flat),
      .status    (status)
   );

   ibp_out_reg #(.WORD_W(WORD_W)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .word_in  ({status, lanes_flat}),
      .out_ready(out_ready),
      .out_valid(out_valid),
      .out_word (out_word)
   );
endmodule

// File: rtl/ibp_checker.sv
module ibp_checker #(
   parameter int unsigned       WORD_W    = 32,
   parameter logic [7:0]        IDLE_CODE = 8'hBC,
   parameter bit                ZERO_FILL = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [7:0]        in_byte,
   input logic              in_is_k,
   input logic              flush,
   input logic              out_ready,
   input logic              out_valid,
   input logic [WORD_W-1:0] out_word
);
   logic idle_in;
   assign idle_in = in_is_k && (in_byte == IDLE_CODE);

   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_word));

   p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !out_ready && !out_valid |=> !out_valid);

   p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && idle_in && !flush && out_ready |=> !out_valid);

   p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid && !flush && out_ready |=> !out_valid);

   p_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_word[25:24] != 2'd0) && (out_word[31:29] == 3'd0));

   if (ZERO_FILL) begin : g_zero
      p_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid && (out_word[25:24] == 2'd1) |-> out_word[23:8] == 16'd0);
      p_zero2_r6: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid && (out_word[25:24] == 2'd2) |-> out_word[23:16] == 8'd0);
   end
endmodule

bind idle_byte_packer ibp_checker #(
   .WORD_W(WORD_W), .IDLE_CODE(IDLE_CODE), .ZERO_FILL(ZERO_FILL)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
   .in_is_k(in_is_k), .flush(flush), .out_ready(out_ready),
   .out_valid(out_valid), .out_word(out_word)
);

// File: tb/idle_byte_packer_tb.sv
module idle_byte_packer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_byte = '0;
   logic        in_is_k = 1'b0;
   logic        in_err = 1'b0;
   logic        flush = 1'b0;
   logic        out_ready = 1'b1;
   logic        out_valid;
   logic [31:0] out_word;

   int vectors = 0;
   int bad = 0;

   // bench-side model of the specified behaviour
   logic [7:0]  m_l [3];
   int          m_cnt = 0;
   logic        m_err = 1'b0;
   logic        m_ovf = 1'b0;
   logic        ev = 1'b0;
   logic [31:0] ew = '0;

   always #10 clk = ~clk;

   idle_byte_packer u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .in_is_k(in_is_k), .in_err(in_err), .flush(flush),
      .out_ready(out_ready), .out_valid(out_valid), .out_word(out_word)
   );

   task automatic step(input logic v, input logic [7:0] b, input logic k,
                       input logic e, input logic fl, input logic rdy,
                       input string tg);
      logic live;
      logic emit;
      @(negedge clk);
      in_valid = v; in_byte = b; in_is_k = k; in_err = e;
      flush = fl; out_ready = rdy;
      live = v && !(k && b == 8'hBC);
      if (rdy) begin
         if (live) begin
            m_l[m_cnt] = b;
            m_cnt++;
            m_err = m_err | e;
         end
         emit = (live && (m_cnt == 3 || k)) || (fl && m_cnt != 0);
         if (emit) begin
            ew = {3'b000, m_ovf, live && k, m_err, 2'(m_cnt),
                  m_l[2], m_l[1], m_l[0]};
            ev = 1'b1;
            m_cnt = 0; m_err = 1'b0; m_ovf = 1'b0;
            for (int i = 0; i < 3; i++) m_l[i] = 8'h00;
         end else begin
            ev = 1'b0;
         end
      end else if (live) begin
         m_ovf = 1'b1;
      end
      @(posedge clk);
      #1;
      vectors++;
      if (out_valid !== ev || (ev && out_word !== ew)) begin
         bad++;
         $display("FAIL %s: valid=%0b word=%h expected valid=%0b word=%h",
                  tg, out_valid, out_word, ev, ew);
      end
   endtask

   initial begin
      for (int i = 0; i < 3; i++) m_l[i] = 8'h00;
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      vectors++;
      if (out_valid !== 1'b0) begin
         bad++;
         $display("FAIL R10: valid=%0b expected valid=0", out_valid);
      end
      // R10: first group after reset starts empty
      step(1, 8'h11, 0, 0, 1, 1, "R10");

      // R2: every byte value as data, including 0xBC without k (R1)
      for (int v = 0; v < 256; v++)
         step(1, 8'(v), 0, 0, 0, 1, (v == 8'hBC) ? "R1" : "R2");
      step(0, 8'h00, 0, 0, 1, 1, "R5");

      // R4 / R1: every code as a k character after one data byte
      for (int c = 0; c < 256; c++) begin
         step(1, 8'h5A, 0, 0, 0, 1, "R4");
         step(1, 8'(c), 1, 0, 0, 1, (c == 8'hBC) ? "R1" : "R4");
         if (c == 8'hBC) step(0, 8'h00, 0, 0, 1, 1, "R6");
      end
      // R4 control as first byte: count 1, upper lanes zero (R6)
      step(1, 8'hF7, 1, 0, 0, 1, "R6");

      // R9 error stickiness and clearing
      step(1, 8'h0B, 0, 1, 0, 1, "R9");
      step(1, 8'h16, 0, 0, 0, 1, "R9");
      step(1, 8'h21, 0, 0, 0, 1, "R9");
      step(1, 8'h2C, 0, 0, 0, 1, "R9");
      step(1, 8'h37, 0, 0, 1, 1, "R9");

      // R1 idle with error flag leaves no trace
      step(1, 8'hBC, 1, 1, 0, 1, "R1");
      step(1, 8'h01, 0, 0, 0, 1, "R1");
      step(1, 8'hBC, 1, 1, 0, 1, "R1");
      step(1, 8'h02, 0, 0, 1, 1, "R1");

      // R5 flush on empty group, flush with byte
      step(0, 8'h00, 0, 0, 1, 1, "R5");
      step(1, 8'h4D, 0, 0, 1, 1, "R5");

      // R11 invalid cycles do not count
      step(0, 8'h99, 0, 0, 0, 1, "R11");
      step(1, 8'hA1, 0, 0, 0, 1, "R11");
      step(0, 8'h98, 1, 1, 0, 1, "R11");
      step(1, 8'hA2, 0, 0, 0, 1, "R11");
      step(1, 8'hA3, 0, 0, 0, 1, "R11");

      // R7 / R8 stall, drop, overflow flag
      step(1, 8'hC1, 0, 0, 0, 1, "R7");
      step(1, 8'hC2, 0, 0, 0, 1, "R7");
      step(1, 8'hC3, 0, 0, 0, 1, "R7");
      step(0, 8'h00, 0, 0, 0, 0, "R7");
      step(1, 8'hD0, 0, 0, 0, 0, "R8");
      step(1, 8'hD1, 0, 0, 1, 0, "R8");
      step(0, 8'h00, 0, 0, 0, 1, "R7");
      step(1, 8'hE1, 0, 0, 1, 1, "R8");
      step(1, 8'hE2, 0, 0, 1, 1, "R8");
      // drop with no pending word, then partial group with control
      step(1, 8'h70, 0, 0, 0, 1, "R8");
      step(1, 8'hD2, 0, 0, 0, 0, "R8");
      step(1, 8'hFB, 1, 0, 0, 1, "R8");
      step(0, 8'h00, 0, 0, 0, 1, "R8");

      $display("  == %0d vectors applied, %0d miscompares ==", vectors, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, bad);
      $finish;
   end
endmodule